// File: doc/BRIEF.md
# Segment Limit and Protection Checker

This block validates one data access against the segment it goes through, before any paging takes place. It is meant for protected mode outside the 64-bit mode. The caller presents the selected segment's index, selector, access rights, base and limit. It also presents the code segment's default-size bit, an address-size override, the virtual address, the access size in bytes, the access kind and a store-check flag. One cycle after the request strobe, the block returns a general-protection fault flag and the linear offset into the segment.

The check has four parts:
- a null-selector test, from which a small set of system segments is exempt;
- a rights test that applies to data-class segments only;
- a choice of 16-bit or 32-bit offset wrap;
- a limit comparison, which is inverted for expand-down segments.

When protection is off, or when 64-bit mode is active, the access passes through unchecked.

Top module: `seg_guard`

## Requirements
- R1: `rsp_valid_o` is high exactly in the cycle after a cycle with `req_valid_i` high. `gp_fault_o` and `lin_off_o` change only on those responses and hold their values otherwise.
- R2: When `prot_en_i` is low or `long_mode_i` is high, the response has `gp_fault_o` = 0 and `lin_off_o` equal to `vaddr_i`, whatever the other inputs are.
- R3: A selector of zero faults, except for segment indices 6, 7, 8 and 9. These are the exempt system segments: two internal scratch segments, the task segment and the interrupt table.
- R4: Segment indices 0 to 6 are data-class. For these, the following accesses fault:
  - a write (`acc_mode_i` = 1) to a segment with `attr_wr_i` = 0;
  - any access with `store_chk_i` = 1 to a segment with `attr_wr_i` = 0;
  - a read (`acc_mode_i` = 0) from a segment with `attr_rd_i` = 0.

  Execute (`acc_mode_i` = 2 or 3) triggers no rights test. Indices 7 to 15 have no rights test.
- R5: The effective offset width is 16 bits when `cs_dsize_i` and `asize_ovr_i` are equal, and 32 bits otherwise.
- R6: The offset is `vaddr_i - seg_base_i`, truncated to the effective width and zero-extended onto `lin_off_o`.
- R7: For a normal segment, the access faults if the offset or the end offset (offset + `acc_size_i` - 1, computed without wrap) is greater than `seg_limit_i`.
- R8: `attr_expdn_i` takes effect only for data-class indices. For such a segment, the access faults if the offset or the end offset is less than or equal to `seg_limit_i`. For other indices, the normal test of R7 applies.
- R9: During and right after reset, `rsp_valid_o`, `gp_fault_o` and `lin_off_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| prot_en_i | input | 1 | Protection enabled |
| long_mode_i | input | 1 | 64-bit mode active (bypass) |
| seg_idx_i | input | 4 | Segment index |
| seg_sel_i | input | 16 | Segment selector |
| attr_wr_i | input | 1 | Segment writable |
| attr_rd_i | input | 1 | Segment readable |
| attr_expdn_i | input | 1 | Segment expands down |
| seg_base_i | input | 32 | Segment base |
| seg_limit_i | input | 32 | Segment limit |
| cs_dsize_i | input | 1 | Code segment default-size bit |
| asize_ovr_i | input | 1 | Address-size override |
| vaddr_i | input | 32 | Virtual address |
| acc_size_i | input | 4 | Access size in bytes, 1 to 15 |
| acc_mode_i | input | 2 | 0 read, 1 write, 2 or 3 execute |
| store_chk_i | input | 1 | Store-check flag |
| rsp_valid_o | output | 1 | Response valid |
| gp_fault_o | output | 1 | General-protection fault |
| lin_off_o | output | 32 | Linear offset |

## Verification
The assertions check the following on every cycle:
- the one-cycle response timing;
- that the outputs hold between responses;
- that bypass gives no fault and an unchanged address;
- that a non-exempt null selector always faults;
- that a write or store check to a non-writable data segment always faults.

Some behaviours need chosen operand values and can only be shown by the bench's scenarios. These are the exact limit boundaries (end offset equal to the limit versus one past it), the 16-bit wrap under each combination of default size and override, the inverted expand-down test and its restriction to data-class segments, and the cases where exemption or execute mode suppresses a fault.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;
  localparam int SEG_IDX_W = 4;
  localparam int NARROW_W  = 16;
  localparam int DATA_LAST = 6;

  localparam logic [1:0] MODE_RD = 2'd0;
  localparam logic [1:0] MODE_WR = 2'd1;

  function automatic logic seg_is_exempt(input logic [SEG_IDX_W-1:0] idx);
    return (idx >= SEG_IDX_W'(6)) && (idx <= SEG_IDX_W'(9));
  endfunction

  function automatic logic seg_is_data(input logic [SEG_IDX_W-1:0] idx);
    return idx <= SEG_IDX_W'(DATA_LAST);
  endfunction
endpackage

// File: rtl/seg_class.sv
module seg_class
  import seg_guard_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic [SEG_IDX_W-1:0] seg_idx_i,
  input  logic [SEL_W-1:0]     seg_sel_i,
  input  logic                 attr_wr_i,
  input  logic                 attr_rd_i,
  input  logic [1:0]           acc_mode_i,
  input  logic                 store_chk_i,
  output logic                 is_data_o,
  output logic                 null_flt_o,
  output logic                 rights_flt_o
);
  logic wr_like;

  assign is_data_o  = seg_is_data(seg_idx_i);
  assign null_flt_o = (seg_sel_i == '0) && !seg_is_exempt(seg_idx_i);

  assign wr_like = (acc_mode_i == MODE_WR) || store_chk_i;

  always_comb begin
    rights_flt_o = 1'b0;
    if (is_data_o) begin
      if (wr_like && !attr_wr_i)                 rights_flt_o = 1'b1;
      if (acc_mode_i == MODE_RD && !attr_rd_i)   rights_flt_o = 1'b1;
    end
  end
endmodule

// File: rtl/seg_offset.sv
module seg_offset
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [ADDR_W-1:0] seg_base_i,
  input  logic              cs_dsize_i,
  input  logic              asize_ovr_i,
  input  logic [SIZE_W-1:0] acc_size_i,
  output logic [ADDR_W-1:0] off_o,
  output logic [ADDR_W:0]   end_o
);
  localparam int END_W = ADDR_W + 1;

  logic [ADDR_W-1:0] diff;
  logic              narrow;

  assign diff   = vaddr_i - seg_base_i;
  assign narrow = (cs_dsize_i == asize_ovr_i);

  generate
    if (ADDR_W > NARROW_W) begin : g_wrap
      assign off_o = narrow ? {{(ADDR_W-NARROW_W){1'b0}}, diff[NARROW_W-1:0]} : diff;
    end else begin : g_flat
      assign off_o = diff;
    end
  endgenerate

  // widened so the end offset cannot wrap
  assign end_o = {1'b0, off_o} + END_W'(acc_size_i) - END_W'(1);
endmodule

// File: rtl/seg_limit_cmp.sv
module seg_limit_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] off_i,
  input  logic [ADDR_W:0]   end_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic              expdn_i,
  output logic              limit_flt_o
);
  logic [ADDR_W:0] lim_w;
  logic            off_above, end_above;

  assign lim_w     = {1'b0, limit_i};
  assign off_above = {1'b0, off_i} > lim_w;
  assign end_above = end_i > lim_w;

  assign limit_flt_o = expdn_i ? (!off_above || !end_above)
                               : ( off_above ||  end_above);
endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int SIZE_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 prot_en_i,
  input  logic                 long_mode_i,
  input  logic [SEG_IDX_W-1:0] seg_idx_i,
  input  logic [SEL_W-1:0]     seg_sel_i,
  input  logic                 attr_wr_i,
  input  logic                 attr_rd_i,
  input  logic                 attr_expdn_i,
  input  logic [ADDR_W-1:0]    seg_base_i,
  input  logic [ADDR_W-1:0]    seg_limit_i,
  input  logic                 cs_dsize_i,
  input  logic                 asize_ovr_i,
  input  logic [ADDR_W-1:0]    vaddr_i,
  input  logic [SIZE_W-1:0]    acc_size_i,
  input  logic [1:0]           acc_mode_i,
  input  logic                 store_chk_i,
  output logic                 rsp_valid_o,
  output logic                 gp_fault_o,
  output logic [ADDR_W-1:0]    lin_off_o
);
  logic              is_data, null_flt, rights_flt, limit_flt;
  logic [ADDR_W-1:0] off;
  logic [ADDR_W:0]   end_off;
  logic              active, flt_d;
  logic [ADDR_W-1:0] off_d;

  seg_class #(.SEL_W(SEL_W)) u_class (
    .seg_idx_i    (seg_idx_i),
    .seg_sel_i    (seg_sel_i),
    .attr_wr_i    (attr_wr_i),
    .attr_rd_i    (attr_rd_i),
    .acc_mode_i   (acc_mode_i),
    .store_chk_i  (store_chk_i),
    .is_data_o    (is_data),
    .null_flt_o   (null_flt),
    .rights_flt_o (rights_flt)
  );

  seg_offset #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_off (
    .vaddr_i     (vaddr_i),
    .seg_base_i  (seg_base_i),
    .cs_dsize_i  (cs_dsize_i),
    .asize_ovr_i (asize_ovr_i),
    .acc_size_i  (acc_size_i),
    .off_o       (off),
    .end_o       (end_off)
  );

  seg_limit_cmp #(.ADDR_W(ADDR_W)) u_lim (
    .off_i       (off),
    .end_i       (end_off),
    .limit_i     (seg_limit_i),
    .expdn_i     (attr_expdn_i && is_data),
    .limit_flt_o (limit_flt)
  );

  assign active = prot_en_i && !long_mode_i;
  assign flt_d  = active && (null_flt || rights_flt || limit_flt);
  assign off_d  = active ? off : vaddr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      gp_fault_o  <= 1'b0;
      lin_off_o   <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        gp_fault_o <= flt_d;
        lin_off_o  <= off_d;
      end
    end
  end

  // R1
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R1
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && $stable(gp_fault_o) && $stable(lin_off_o)));
  // R2
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (!prot_en_i || long_mode_i)) |=> (!gp_fault_o && lin_off_o == $past(vaddr_i)));
  // R3
  null_flt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && prot_en_i && !long_mode_i && seg_sel_i == '0 && !seg_is_exempt(seg_idx_i))
      |=> gp_fault_o);
  // R4
  rights_flt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && prot_en_i && !long_mode_i && seg_is_data(seg_idx_i) && !attr_wr_i &&
     (acc_mode_i == MODE_WR || store_chk_i)) |=> gp_fault_o);
endmodule

// File: tb/tb_seg_guard.sv
module tb_seg_guard;
  typedef struct packed {
    logic        prot;
    logic        lm;
    logic [3:0]  idx;
    logic [15:0] sel;
    logic        wr;
    logic        rd;
    logic        ed;
    logic [31:0] base;
    logic [31:0] limit;
    logic        dsz;
    logic        ovr;
    logic [31:0] va;
    logic [3:0]  size;
    logic [1:0]  mode;
    logic        sc;
    logic        efl;
    logic [31:0] eoff;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    // R7 in range
    '{1'b1,1'b0,4'd3,16'h10,1'b1,1'b1,1'b0,32'h1000,32'hFFFF,1'b1,1'b0,32'h1100,4'd4,2'd0,1'b0,1'b0,32'h100},
    // R7 end offset equal to limit
    '{1'b1,1'b0,4'd3,16'h10,1'b1,1'b1,1'b0,32'h1000,32'hFFFF,1'b1,1'b0,32'h10FFC,4'd4,2'd0,1'b0,1'b0,32'hFFFC},
    // R7 end offset one past limit
    '{1'b1,1'b0,4'd3,16'h10,1'b1,1'b1,1'b0,32'h1000,32'hFFFF,1'b1,1'b0,32'h10FFD,4'd4,2'd0,1'b0,1'b1,32'hFFFD},
    // R7 offset past limit
    '{1'b1,1'b0,4'd3,16'h10,1'b1,1'b1,1'b0,32'h1000,32'hFFFF,1'b1,1'b0,32'h11000,4'd4,2'd0,1'b0,1'b1,32'h10000},
    // R5 R6 both clear -> 16-bit wrap
    '{1'b1,1'b0,4'd3,16'h10,1'b1,1'b1,1'b0,32'h1000,32'hFFFF,1'b0,1'b0,32'h0800,4'd4,2'd0,1'b0,1'b0,32'hF800},
    // R5 R6 both set -> 16-bit wrap
    '{1'b1,1'b0,4'd3,16'h10,1'b1,1'b1,1'b0,32'h1000,32'hF000,1'b1,1'b1,32'h0800,4'd4,2'd0,1'b0,1'b1,32'hF800},
    // R5 R6 differing -> 32-bit
    '{1'b1,1'b0,4'd3,16'h10,1'b1,1'b1,1'b0,32'h1000,32'hFFFF,1'b0,1'b1,32'h0800,4'd4,2'd0,1'b0,1'b1,32'hFFFFF800},
    // R8 expand-down above limit passes
    '{1'b1,1'b0,4'd3,16'h10,1'b1,1'b1,1'b1,32'h0,32'h0FFF,1'b1,1'b0,32'h1000,4'd4,2'd0,1'b0,1'b0,32'h1000},
    // R8 expand-down at/below limit faults
    '{1'b1,1'b0,4'd3,16'h10,1'b1,1'b1,1'b1,32'h0,32'h0FFF,1'b1,1'b0,32'h0FFE,4'd4,2'd0,1'b0,1'b1,32'h0FFE},
    // R8 R3 expand-down ignored on idx 8, null exempt
    '{1'b1,1'b0,4'd8,16'h0,1'b1,1'b1,1'b1,32'h0,32'h0FFF,1'b1,1'b0,32'h0800,4'd4,2'd0,1'b0,1'b0,32'h0800},
    // R3 null selector faults
    '{1'b1,1'b0,4'd3,16'h0,1'b1,1'b1,1'b0,32'h0,32'hFFFF,1'b1,1'b0,32'h10,4'd4,2'd0,1'b0,1'b1,32'h10},
    // R3 null exempt idx 9
    '{1'b1,1'b0,4'd9,16'h0,1'b1,1'b1,1'b0,32'h0,32'hFFFF,1'b1,1'b0,32'h10,4'd4,2'd0,1'b0,1'b0,32'h10},
    // R3 null exempt idx 7
    '{1'b1,1'b0,4'd7,16'h0,1'b1,1'b1,1'b0,32'h0,32'hFFFF,1'b1,1'b0,32'h10,4'd4,2'd0,1'b0,1'b0,32'h10},
    // R4 write to non-writable
    '{1'b1,1'b0,4'd3,16'h10,1'b0,1'b1,1'b0,32'h0,32'hFFFF,1'b1,1'b0,32'h10,4'd4,2'd1,1'b0,1'b1,32'h10},
    // R4 store-check on read
    '{1'b1,1'b0,4'd3,16'h10,1'b0,1'b1,1'b0,32'h0,32'hFFFF,1'b1,1'b0,32'h10,4'd4,2'd0,1'b1,1'b1,32'h10},
    // R4 read from non-readable
    '{1'b1,1'b0,4'd3,16'h10,1'b1,1'b0,1'b0,32'h0,32'hFFFF,1'b1,1'b0,32'h10,4'd4,2'd0,1'b0,1'b1,32'h10},
    // R4 execute has no rights test
    '{1'b1,1'b0,4'd3,16'h10,1'b0,1'b0,1'b0,32'h0,32'hFFFF,1'b1,1'b0,32'h10,4'd4,2'd2,1'b0,1'b0,32'h10},
    // R4 non-data idx 10 has no rights test
    '{1'b1,1'b0,4'd10,16'h10,1'b0,1'b0,1'b0,32'h0,32'hFFFF,1'b1,1'b0,32'h10,4'd4,2'd1,1'b0,1'b0,32'h10},
    // R2 protection off
    '{1'b0,1'b0,4'd3,16'h0,1'b0,1'b0,1'b0,32'h1000,32'h0,1'b1,1'b0,32'h12345678,4'd4,2'd1,1'b1,1'b0,32'h12345678},
    // R2 long mode
    '{1'b1,1'b1,4'd3,16'h0,1'b0,1'b0,1'b0,32'h1000,32'h0,1'b1,1'b0,32'h12345678,4'd4,2'd1,1'b1,1'b0,32'h12345678}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid, prot, lm, wr, rd, ed, dsz, ovr, sc;
  logic [3:0]  idx, size;
  logic [15:0] sel;
  logic [31:0] base, limit, va;
  logic [1:0]  mode;
  logic        rsp_valid, gp_fault;
  logic [31:0] lin_off;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_guard dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid),
    .prot_en_i(prot), .long_mode_i(lm), .seg_idx_i(idx), .seg_sel_i(sel),
    .attr_wr_i(wr), .attr_rd_i(rd), .attr_expdn_i(ed),
    .seg_base_i(base), .seg_limit_i(limit), .cs_dsize_i(dsz), .asize_ovr_i(ovr),
    .vaddr_i(va), .acc_size_i(size), .acc_mode_i(mode), .store_chk_i(sc),
    .rsp_valid_o(rsp_valid), .gp_fault_o(gp_fault), .lin_off_o(lin_off)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    prot = v.prot; lm = v.lm; idx = v.idx; sel = v.sel; wr = v.wr; rd = v.rd;
    ed = v.ed; base = v.base; limit = v.limit; dsz = v.dsz; ovr = v.ovr;
    va = v.va; size = v.size; mode = v.mode; sc = v.sc;
  endtask

  task automatic run_vec(input vec_t v, input int n);
    @(negedge clk);
    drive(v);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check($sformatf("R1 rsp_valid vec%0d", n), 32'(rsp_valid), 32'd1);
    check($sformatf("R3/R4/R7/R8 fault vec%0d", n), 32'(gp_fault), 32'(v.efl));
    check($sformatf("R6 offset vec%0d", n), lin_off, v.eoff);
  endtask

  initial begin
    req_valid = 1'b0;
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    check("R9 fault in reset", 32'(gp_fault), 32'd0);
    check("R9 offset in reset", lin_off, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 rsp_valid after reset", 32'(rsp_valid), 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R1 hold: a faulting result stays while inputs change without a strobe
    run_vec(VECS[2], 2);
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    check("R1 no response without strobe", 32'(rsp_valid), 32'd0);
    check("R1 fault held", 32'(gp_fault), 32'd1);
    check("R1 offset held", lin_off, 32'hFFFD);

    // R1 back-to-back strobes
    @(negedge clk);
    drive(VECS[10]);
    req_valid = 1'b1;
    @(negedge clk);
    check("R1 b2b first fault", 32'(gp_fault), 32'd1);
    drive(VECS[0]);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 b2b second rsp_valid", 32'(rsp_valid), 32'd1);
    check("R1 b2b second fault", 32'(gp_fault), 32'd0);
    check("R1 b2b second offset", lin_off, 32'h100);
    @(negedge clk);
    check("R1 rsp_valid drops", 32'(rsp_valid), 32'd0);

    // R9 mid-run reset clears a live fault
    run_vec(VECS[13], 13);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 fault cleared by reset", 32'(gp_fault), 32'd0);
    check("R9 offset cleared by reset", lin_off, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule